// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block is the output half of a timer channel. It takes a free-running counter value from outside and compares it with an active compare value. Software writes that value either straight into the active register or into a holding buffer, and the buffer is copied across on the next counter overflow pulse. The comparison produces a raw PWM reference, which is high while the counter is below the compare value. The block also reports an "equal" flag and a "greater than" flag for the counter.

The reference is split into a main leg and a complementary leg. A programmable dead time delays the rising edge of each leg, so the two legs are never active together. Each leg then passes through its own polarity inversion and its own enable. A break input forces both pins to their programmed idle levels in the same cycle. The break also clears a master output enable, and the outputs return to normal only after that enable is set again with break low.

Top module: `cpwm_stage`

## Requirements
- R1: With the preload buffer off (`preload_en_i`=0), a pulse on `cmp_wr_i` makes `cmp_wdata_i` the active compare value from the next clock edge.
- R2: With the preload buffer on, a write only fills the buffer. The active compare value stays unchanged until a clock edge at which `ovf_i` is 1, and from that edge on it equals the buffered value.
- R3: `cmp_eq_o` is 1 exactly when `cnt_i` equals the active compare value, and `cmp_gt_o` is 1 exactly when `cnt_i` is greater than it. Both are combinational in `cnt_i`.
- R4: When `mode_i` is nonzero, the reference is 1 while `cnt_i` is less than the active compare value and 0 otherwise, so a compare value of 0 keeps it low. When `mode_i` is 0 and the outputs are running, both pins are 0.
- R5: The reference is registered once. The main leg is 1 at an edge only when the last `dead_i`+1 registered reference samples were all 1. The complementary leg is 1 only when they were all 0. The two legs are never 1 together, and with `dead_i`=0 each leg simply follows the registered reference.
- R6: A high phase of L cycles gives max(L−`dead_i`,0) cycles of main leg per period, and a low phase gives the same for the complementary leg. A phase no longer than the dead time therefore produces no pulse on that leg.
- R7: While the outputs are running, each pin equals its leg XOR its polarity bit (1 = inverted) when its enable bit is 1, and is 0 when its enable bit is 0.
- R8: While `brk_i` is 1, `out_main_o` equals `idle_main_i` and `out_comp_o` equals `idle_comp_i`, starting in the same cycle. Each clock edge that sees `brk_i` high clears the master output enable.
- R9: The master output enable is 0 after reset, and the pins then show the idle levels. It becomes 1 only at an edge where `moe_set_i` is 1 and `brk_i` is 0, and until then the pins keep the idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_i | input | CNT_W | Counter value from the timebase |
| ovf_i | input | 1 | Counter overflow pulse, loads the buffered compare value |
| mode_i | input | 3 | Channel mode; nonzero selects PWM output |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write data |
| preload_en_i | input | 1 | 1 = writes go through the buffer, 0 = writes are immediate |
| dead_i | input | DT_W | Dead time in clock cycles |
| pol_main_i | input | 1 | Main pin polarity, 1 = inverted |
| pol_comp_i | input | 1 | Complementary pin polarity, 1 = inverted |
| en_main_i | input | 1 | Main pin enable |
| en_comp_i | input | 1 | Complementary pin enable |
| idle_main_i | input | 1 | Main pin level while stopped or in break |
| idle_comp_i | input | 1 | Complementary pin level while stopped or in break |
| brk_i | input | 1 | Break, active high |
| moe_set_i | input | 1 | Strobe that sets the master output enable |
| out_main_o | output | 1 | Main pin |
| out_comp_o | output | 1 | Complementary pin |
| cmp_eq_o | output | 1 | Counter equals the active compare value |
| cmp_gt_o | output | 1 | Counter is greater than the active compare value |

## Verification
The bench sweeps every compare value from 0 to the period, including full duty, against dead times on both sides of each phase length, and counts the pin-high cycles in each period.
- An off-by-one in the dead-time counter, or a leg that leaks while suppressed, changes those counts.
- A preload that copies on the write instead of on overflow moves the equal flag early.
- A break that acts through a register shows the running level for one cycle.
- An enable that comes back when break drops, or that can be set while break is held, shows running levels where the idle levels are expected.

// File: rtl/cpwm_pkg.sv
// Shared types for the complementary PWM output stage.
// Assumes: two output legs, index 0 = main, index 1 = complementary.
package cpwm_pkg;

    localparam int NUM_LEGS = 2;
    localparam int LEG_MAIN = 0;
    localparam int LEG_COMP = 1;

    // Per-leg pin configuration.
    typedef struct packed {
        logic pol;   // 1 = inverted output
        logic en;    // 1 = leg drives its waveform
        logic idle;  // level while stopped or in break
    } leg_cfg_t;

endpackage

// File: rtl/cpwm_compare.sv
// Active compare register with an optional overflow-loaded buffer, the
// counter comparator, and the raw PWM reference.
// Assumes: ovf_i is a single-cycle pulse; the counter is driven externally.
module cpwm_compare #(
    parameter int CNT_W  = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ovf_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              preload_en_i,
    output logic              eq_o,
    output logic              gt_o,
    output logic              ref_o
);

    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] act_q;

    // Buffer register: captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= '0;
        else if (wr_i)  pend_q <= wdata_i;
    end

    // Active register: immediate write, or copy from buffer on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                        act_q <= '0;
        else if (wr_i && !preload_en_i)    act_q <= wdata_i;
        else if (ovf_i && preload_en_i)    act_q <= pend_q;
    end

    // Comparator flags and PWM reference.
    always_comb begin
        eq_o  = (cnt_i == act_q);
        gt_o  = (cnt_i > act_q);
        ref_o = (mode_i != '0) && (cnt_i < act_q);
    end

    assert_direct_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !preload_en_i) |=> (act_q == $past(wdata_i)));

    assert_preload_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && !ovf_i) |=> $stable(act_q));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(eq_o && gt_o));

    assert_ref_low_at_or_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_o || gt_o) |-> !ref_o);

endmodule

// File: rtl/cpwm_deadtime.sv
// Dead-time generator: registers the reference and delays the rising edge
// of each leg until the reference has been stable for dead_i more cycles.
// Assumes: dead_i may change at any time; the run counter saturates.
module cpwm_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            main_o,
    output logic            comp_o
);

    localparam logic [DT_W-1:0] RUN_MAX = '1;

    logic            ref_q;
    logic [DT_W-1:0] run_q;
    logic            settled;

    // Reference sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_i;
    end

    // Cycles the sampled reference has held its level, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= '0;
        else if (ref_i != ref_q)   run_q <= '0;
        else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end

    // Leg levels: a leg turns on once its phase has outlasted the dead time.
    always_comb begin
        settled = (run_q >= dead_i);
        main_o  = ref_q && settled;
        comp_o  = !ref_q && settled;
    end

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_o && comp_o));

    assert_zero_dt_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_i == '0) |-> (main_o == ref_q) && (comp_o == !ref_q));

endmodule

// File: rtl/cpwm_outctl.sv
// Output control: master output enable with break clearing, and per-leg
// polarity, enable and idle-level selection.
// Assumes: brk_i acts combinationally on the pins; the enable is set only
// by moe_set_i while brk_i is low.
module cpwm_outctl
    import cpwm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LEGS-1:0]     leg_i,
    input  leg_cfg_t [NUM_LEGS-1:0] cfg_i,
    input  logic                    mode_on_i,
    input  logic                    brk_i,
    input  logic                    moe_set_i,
    output logic [NUM_LEGS-1:0]     pin_o
);

    logic moe_q;
    logic run_en;

    // Master output enable: break clears, set strobe sets.
    always_ff @(posedge clk) begin
        if (!rst_n)          moe_q <= 1'b0;
        else if (brk_i)      moe_q <= 1'b0;
        else if (moe_set_i)  moe_q <= 1'b1;
    end

    // Outputs run only with the enable set and no break present.
    always_comb run_en = moe_q && !brk_i;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        // Pin mux: idle level, off level, or polarised leg.
        always_comb begin
            if (!run_en)                        pin_o[g] = cfg_i[g].idle;
            else if (!mode_on_i || !cfg_i[g].en) pin_o[g] = 1'b0;
            else                                 pin_o[g] = leg_i[g] ^ cfg_i[g].pol;
        end

        assert_brk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            brk_i |-> (pin_o[g] == cfg_i[g].idle));

        assert_disabled_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (moe_q && !brk_i && !cfg_i[g].en) |-> (pin_o[g] == 1'b0));
    end

    assert_brk_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> !moe_q);

    assert_stay_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && !moe_set_i) |=> !moe_q);

endmodule

// File: rtl/cpwm_stage.sv
// Complementary PWM output stage: compare with optional preload, dead-time
// split into main/complementary legs, polarity, enables and break forcing.
// Assumes: counter and overflow pulse come from an external timebase.
module cpwm_stage
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DT_W   = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ovf_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cmp_wr_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic              preload_en_i,
    input  logic [DT_W-1:0]   dead_i,
    input  logic              pol_main_i,
    input  logic              pol_comp_i,
    input  logic              en_main_i,
    input  logic              en_comp_i,
    input  logic              idle_main_i,
    input  logic              idle_comp_i,
    input  logic              brk_i,
    input  logic              moe_set_i,
    output logic              out_main_o,
    output logic              out_comp_o,
    output logic              cmp_eq_o,
    output logic              cmp_gt_o
);

    logic                    ref_w;
    logic [NUM_LEGS-1:0]     leg_w;
    logic [NUM_LEGS-1:0]     pin_w;
    leg_cfg_t [NUM_LEGS-1:0] cfg_w;

    // Gather per-leg configuration and scatter pins.
    always_comb begin
        cfg_w[LEG_MAIN] = '{pol: pol_main_i, en: en_main_i, idle: idle_main_i};
        cfg_w[LEG_COMP] = '{pol: pol_comp_i, en: en_comp_i, idle: idle_comp_i};
        out_main_o      = pin_w[LEG_MAIN];
        out_comp_o      = pin_w[LEG_COMP];
    end

    cpwm_compare #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt_i),
        .ovf_i        (ovf_i),
        .mode_i       (mode_i),
        .wr_i         (cmp_wr_i),
        .wdata_i      (cmp_wdata_i),
        .preload_en_i (preload_en_i),
        .eq_o         (cmp_eq_o),
        .gt_o         (cmp_gt_o),
        .ref_o        (ref_w)
    );

    cpwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_w),
        .dead_i (dead_i),
        .main_o (leg_w[LEG_MAIN]),
        .comp_o (leg_w[LEG_COMP])
    );

    cpwm_outctl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .leg_i     (leg_w),
        .cfg_i     (cfg_w),
        .mode_on_i (mode_i != '0),
        .brk_i     (brk_i),
        .moe_set_i (moe_set_i),
        .pin_o     (pin_w)
    );

endmodule

// File: tb/tb_cpwm_stage.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps compare value and dead time over a short
// period, plus preload, polarity, enable, mode and break scenarios.
module tb_cpwm_stage;

    localparam int CNT_W = 8;
    localparam int DT_W  = 8;
    localparam int PER   = 10;
    localparam int HLEN  = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic ovf = 1'b0;
    logic [2:0] mode = 3'd6;
    logic wr = 1'b0;
    logic [CNT_W-1:0] wdata = '0;
    logic pre = 1'b0;
    logic [DT_W-1:0] dead = '0;
    logic pol_m = 1'b0, pol_c = 1'b0, en_m = 1'b1, en_c = 1'b1;
    logic idl_m = 1'b1, idl_c = 1'b0, brk = 1'b0, mset = 1'b0;
    logic out_m, out_c, eq, gt;

    int checks = 0;
    int failures = 0;
    int m_act = 0, m_buf = 0;
    bit m_moe = 1'b0;
    bit hist [HLEN];
    int nvalid = 0;
    int hi_m = 0, hi_c = 0;

    always #2 clk = ~clk;

    cpwm_stage #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .ovf_i(ovf), .mode_i(mode),
        .cmp_wr_i(wr), .cmp_wdata_i(wdata), .preload_en_i(pre), .dead_i(dead),
        .pol_main_i(pol_m), .pol_comp_i(pol_c), .en_main_i(en_m), .en_comp_i(en_c),
        .idle_main_i(idl_m), .idle_comp_i(idl_c), .brk_i(brk), .moe_set_i(mset),
        .out_main_o(out_m), .out_comp_o(out_c), .cmp_eq_o(eq), .cmp_gt_o(gt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected pin levels from the current inputs and model state.
    task automatic check_pins(input string tag);
        bit all_hi = 1'b1, all_lo = 1'b1, leg_m, leg_c, em, ec;
        for (int i = 0; i <= int'(dead); i++) begin
            if (hist[i]) all_lo = 1'b0; else all_hi = 1'b0;
        end
        leg_m = (nvalid >= int'(dead) + 1) && all_hi;
        leg_c = (nvalid >= int'(dead) + 1) && all_lo;
        if (brk || !m_moe) begin em = idl_m; ec = idl_c; end
        else begin
            em = (mode != 0 && en_m) ? (leg_m ^ pol_m) : 1'b0;
            ec = (mode != 0 && en_c) ? (leg_c ^ pol_c) : 1'b0;
        end
        check(tag, "out_main", int'(out_m), int'(em));
        check(tag, "out_comp", int'(out_c), int'(ec));
    endtask

    // One clock: update the model for the edge just taken, check, advance counter.
    task automatic tick(input string tag);
        int nact;
        bit rprev;
        @(negedge clk);
        rprev = (mode != 0) && (int'(cnt) < m_act);
        for (int i = HLEN - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = rprev;
        if (nvalid < HLEN) nvalid++;
        nact = m_act;
        if (wr && !pre) nact = int'(wdata);
        else if (ovf && pre) nact = m_buf;
        if (wr) m_buf = int'(wdata);
        m_act = nact;
        if (brk) m_moe = 1'b0; else if (mset) m_moe = 1'b1;
        check("R3", "cmp_eq", int'(eq), int'(int'(cnt) == m_act));
        check("R3", "cmp_gt", int'(gt), int'(int'(cnt) > m_act));
        check_pins(tag);
        if (out_m) hi_m++;
        if (out_c) hi_c++;
        wr = 1'b0;
        mset = 1'b0;
        cnt = (int'(cnt) == PER - 1) ? '0 : cnt + 1'b1;
        ovf = (int'(cnt) == PER - 1);
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int em, ec, c, d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < HLEN; i++) hist[i] = 1'b0;
        nvalid = 1;
        // Reset state: enable off, idle levels on the pins (R9)
        check("R9", "reset out_main", int'(out_m), 1);
        check("R9", "reset out_comp", int'(out_c), 0);
        check("R3", "reset cmp_eq", int'(eq), 1);
        ticks("R9", 5);
        mset = 1'b1;
        tick("R9");

        // Sweep compare value and dead time (R4, R5, R6)
        for (c = 0; c <= PER; c++) begin
            for (d = 0; d <= 5; d++) begin
                wdata = CNT_W'(c); wr = 1'b1; dead = DT_W'(d);
                ticks("R5", 2 * PER);
                hi_m = 0; hi_c = 0;
                ticks("R5", PER);
                em = (c >= PER) ? PER : ((c > d) ? c - d : 0);
                ec = (c == 0) ? PER : ((PER - c > d) ? PER - c - d : 0);
                if (c == 0 || c >= PER) begin
                    check("R4", "main high count", hi_m, em);
                    check("R4", "comp high count", hi_c, ec);
                end else begin
                    check("R6", "main high count", hi_m, em);
                    check("R6", "comp high count", hi_c, ec);
                end
            end
        end

        // Polarity and enable combinations (R7)
        wdata = 8'd4; wr = 1'b1; dead = 8'd1;
        for (int k = 0; k < 16; k++) begin
            {pol_m, pol_c, en_m, en_c} = 4'(k);
            ticks("R7", 2 * PER);
        end
        {pol_m, pol_c, en_m, en_c} = 4'b0011;

        // Mode zero forces running pins off (R4)
        mode = 3'd0;
        ticks("R4", 2 * PER);
        mode = 3'd6;
        ticks("R4", PER);

        // Preload: write held until overflow (R2), then immediate again (R1)
        pre = 1'b1;
        while (int'(cnt) != 3) tick("R2");
        wdata = 8'd7; wr = 1'b1;
        ticks("R2", 3 * PER);
        pre = 1'b0;
        while (int'(cnt) != 2) tick("R1");
        wdata = 8'd5; wr = 1'b1;
        tick("R1");
        check("R1", "cmp_gt after direct write", int'(gt), int'(int'(cnt) > 5));
        ticks("R1", 2 * PER);

        // Break acts in the same cycle (R8)
        brk = 1'b1;
        #1;
        check("R8", "same-cycle main idle", int'(out_m), int'(idl_m));
        check("R8", "same-cycle comp idle", int'(out_c), int'(idl_c));
        ticks("R8", 3);
        idl_m = 1'b0; idl_c = 1'b1;
        ticks("R8", 3);
        // Release without re-enable keeps idle; set during break is refused (R9)
        brk = 1'b0;
        ticks("R9", 5);
        brk = 1'b1; mset = 1'b1;
        tick("R9");
        brk = 1'b0;
        ticks("R9", 3);
        check("R9", "still idle main", int'(out_m), 0);
        check("R9", "still idle comp", int'(out_c), 1);
        mset = 1'b1;
        tick("R9");
        ticks("R5", 2 * PER);

        // Large dead time fully suppresses both legs (R6)
        dead = 8'd200;
        ticks("R6", PER);
        hi_m = 0; hi_c = 0;
        ticks("R6", PER);
        check("R6", "main suppressed", hi_m, 0);
        check("R6", "comp suppressed", hi_c, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule